// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port for a small microcontroller. Each pin has a direction bit and a bit in the output data latch. A latch bit drives its pin whenever that pin is an output. One shared control bit, active low, turns on weak pull-ups for every pin that is an input. Software reaches the port through plain register strobes and an 8-bit data bus. Writing the data register changes only the output latch. Reading it returns the levels seen on the pins.

The port also detects changes on its inputs. Each input pin is passed through a two-stage synchronizer and then compared with its own bit in the output latch. Any difference sets a sticky interrupt flag, and the same flag drives a wake request. Software ends the mismatch by reading the port and writing the value it read back into the latch. It then clears the flag. If a mismatch is still present when the clear arrives, the flag stays set.

The register strobes, the flag clear and the pin signals are single-cycle control inputs with no handshake. Every register write takes effect at the clock edge that ends the cycle in which the write is presented. The read bus is combinational from the current state, so a read and a write in the same cycle return the value from before the write.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the output latch is 0x00, the direction register is 0xFF (all inputs), the pull-up control bit is 0 (pull-ups on) and the interrupt flag is 0.
- R2: A direction write stores wdata_i at the next edge. A direction bit of 1 makes its pin an input (pin_oe_o bit 0). A bit of 0 makes it an output (pin_oe_o bit 1).
- R3: A data write updates only the output latch at the next edge, and pin_out_o shows the latch. Read select 0 returns the pin levels after two synchronizer edges, not the latch.
- R4: Read select 1 returns the direction register. Read select 2 returns the control register: bit 0 is the pull-up disable bit and the other bits are 0. A control write stores wdata_i bit 0. Read select 3 returns 0.
- R5: pin_pu_o bit i is 1 only when pin i is an input and the pull-up disable bit is 0. A pull-up is never on for an output pin.
- R6: The flag is set at the edge after a synchronized input pin differs from its latch bit. A pin change therefore reaches flag_o on the third edge after it is applied. A pin that becomes an input while it mismatches sets the flag at the second edge after the direction write.
- R7: flag_clr_i clears the flag at the next edge only if no mismatch is present in that cycle. If a mismatch is present, setting wins.
- R8: A read of select 0 that shares its cycle with a data write returns the value from before the write. Writing the value that was read ends the mismatch, and after a clear the flag stays 0.
- R9: wake_o follows flag_o in every cycle.
- R10: Pins set as outputs never affect the flag, whatever their level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 1 | Write strobe for the output data latch |
| wr_dir_i | input | 1 | Write strobe for the direction register |
| wr_ctl_i | input | 1 | Write strobe for the control register (pull-up disable) |
| wdata_i | input | 8 | Write data bus |
| rd_sel_i | input | 2 | Read select: 0 pins, 1 direction, 2 control, 3 zero |
| rdata_o | output | 8 | Read data bus (combinational) |
| flag_clr_i | input | 1 | Clears the interrupt flag unless a mismatch is present |
| pin_in_i | input | 8 | Raw pin levels from the pads |
| pin_out_o | output | 8 | Output value for each pin |
| pin_oe_o | output | 8 | Output enable for each pin |
| pin_pu_o | output | 8 | Weak pull-up enable for each pin |
| flag_o | output | 1 | Port change interrupt flag |
| wake_o | output | 1 | Wake request from sleep |

## Verification
A wrong latch or direction bit shows on pin_out_o or pin_oe_o one cycle after the write that caused it. Through the comparison, it also makes the flag rise, or fail to rise, one edge later. A wrong synchronizer depth shifts the flag edge away from the third cycle after a pin change, and the bench checks each of those cycles. A clear that wins over a live mismatch, or a flag that sets again after the mismatch has ended, shows on flag_o and wake_o at the edge after the clear.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  typedef enum logic [1:0] {
    RSEL_PINS = 2'd0,
    RSEL_DIR  = 2'd1,
    RSEL_CTL  = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;

  localparam int CTL_PU_OFF_BIT = 0;

endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= din_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_i,
  input  logic             wr_dir_i,
  input  logic             wr_ctl_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [1:0]       rd_sel_i,
  input  logic [WIDTH-1:0] pins_sync_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic             pu_off_o,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic             pu_off_q;
  rsel_e            rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      dir_q    <= '1;
      pu_off_q <= 1'b0;
    end else begin
      if (wr_data_i) latch_q  <= wdata_i;
      if (wr_dir_i)  dir_q    <= wdata_i;
      if (wr_ctl_i)  pu_off_q <= wdata_i[CTL_PU_OFF_BIT];
    end
  end

  assign rsel = rsel_e'(rd_sel_i);

  always_comb begin
    unique case (rsel)
      RSEL_PINS: rdata_o = pins_sync_i;
      RSEL_DIR:  rdata_o = dir_q;
      RSEL_CTL:  rdata_o = {{(WIDTH-1){1'b0}}, pu_off_q};
      default:   rdata_o = '0;
    endcase
  end

  assign latch_o  = latch_q;
  assign dir_o    = dir_q;
  assign pu_off_o = pu_off_q;

  // R3
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_i |=> (latch_q == $past(wdata_i)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_i |=> $stable(latch_q));

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_i |=> (dir_q == $past(wdata_i)));

endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_sync_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             clr_i,
  output logic             flag_o
);

  logic [WIDTH-1:0] diff_bits;
  logic             mismatch;
  logic             flag_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign diff_bits[i] = dir_i[i] & (pins_sync_i[i] ^ latch_i[i]);
  end

  assign mismatch = |diff_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (mismatch) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  set_on_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag_q);

  // R7
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !mismatch) |=> !flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_i,
  input  logic             wr_dir_i,
  input  logic             wr_ctl_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [1:0]       rd_sel_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             flag_clr_i,
  input  logic [WIDTH-1:0] pin_in_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_pu_o,
  output logic             flag_o,
  output logic             wake_o
);

  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] latch;
  logic [WIDTH-1:0] dir;
  logic             pu_off;
  logic             flag;

  gpio_chg_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (pin_in_i),
    .dout_o (pins_sync)
  );

  gpio_chg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_i   (wr_data_i),
    .wr_dir_i    (wr_dir_i),
    .wr_ctl_i    (wr_ctl_i),
    .wdata_i     (wdata_i),
    .rd_sel_i    (rd_sel_i),
    .pins_sync_i (pins_sync),
    .latch_o     (latch),
    .dir_o       (dir),
    .pu_off_o    (pu_off),
    .rdata_o     (rdata_o)
  );

  gpio_chg_detect #(.WIDTH(WIDTH)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_sync_i (pins_sync),
    .latch_i     (latch),
    .dir_i       (dir),
    .clr_i       (flag_clr_i),
    .flag_o      (flag)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pin_out_o[i] = latch[i];
    assign pin_oe_o[i]  = ~dir[i];
    assign pin_pu_o[i]  = dir[i] & ~pu_off;
  end

  assign flag_o = flag;
  assign wake_o = flag;

  // R5
  pu_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu_o & pin_oe_o) == '0);

  // R2
  oe_after_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_i |=> (pin_oe_o == ~$past(wdata_i)));

endmodule

// File: tb/gpio_chg_port_tb_top.sv
module gpio_chg_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_data_i = 1'b0, wr_dir_i = 1'b0, wr_ctl_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [1:0] rd_sel_i = '0;
  logic [7:0] rdata_o;
  logic       flag_clr_i = 1'b0;
  logic [7:0] pin_in_i = '0;
  logic [7:0] pin_out_o, pin_oe_o, pin_pu_o;
  logic       flag_o, wake_o;

  always #5 clk = ~clk;

  gpio_chg_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data_i), .wr_dir_i(wr_dir_i),
    .wr_ctl_i(wr_ctl_i), .wdata_i(wdata_i), .rd_sel_i(rd_sel_i),
    .rdata_o(rdata_o), .flag_clr_i(flag_clr_i), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o),
    .flag_o(flag_o), .wake_o(wake_o)
  );

  typedef struct {
    string      tag;
    int         sel;
    logic [7:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  // Monitor: pops expected items and compares against the outputs at negedge
  always @(negedge clk) begin
    item_t      it;
    logic [7:0] act;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.sel)
        0: act = rdata_o;
        1: act = pin_out_o;
        2: act = pin_oe_o;
        3: act = pin_pu_o;
        4: act = {7'b0, flag_o};
        default: act = {7'b0, wake_o};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: act %h exp %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input string tag, input int sel, input logic [7:0] exp);
    sb_q.push_back('{tag: tag, sel: sel, exp: exp});
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): act running exp done");
      finish_test();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_val("R1 pin_out", 1, 8'h00);
    expect_val("R1 pin_oe", 2, 8'h00);
    expect_val("R1 pin_pu", 3, 8'hFF);
    expect_val("R1 flag", 4, 8'h00);
    rd_sel_i = 2'd1;
    expect_val("R1 dir read", 0, 8'hFF);
    step();
    rd_sel_i = 2'd2;
    expect_val("R1 ctl read", 0, 8'h00);
    step();

    // R4 / R5 control register
    wr_ctl_i = 1'b1; wdata_i = 8'h01;
    step();
    wr_ctl_i = 1'b0;
    expect_val("R4 ctl read", 0, 8'h01);
    expect_val("R5 pu off", 3, 8'h00);
    step();
    rd_sel_i = 2'd3;
    expect_val("R4 sel3 zero", 0, 8'h00);
    wr_ctl_i = 1'b1; wdata_i = 8'h00;
    step();
    wr_ctl_i = 1'b0;
    expect_val("R5 pu on", 3, 8'hFF);

    // R2 direction
    wr_dir_i = 1'b1; wdata_i = 8'h0F;
    step();
    wr_dir_i = 1'b0;
    expect_val("R2 oe", 2, 8'hF0);
    expect_val("R5 pu inputs only", 3, 8'h0F);

    // R3 data write
    wr_data_i = 1'b1; wdata_i = 8'hA0;
    step();
    wr_data_i = 1'b0;
    expect_val("R3 pin_out", 1, 8'hA0);
    step();
    expect_val("R10 flag outputs differ", 4, 8'h00);

    // R3 pin read path and R10
    rd_sel_i = 2'd0;
    pin_in_i = 8'h30;
    step(4);
    expect_val("R3 pin read", 0, 8'h30);
    expect_val("R10 flag", 4, 8'h00);
    expect_val("R3 latch unchanged", 1, 8'hA0);

    // R6 latency
    pin_in_i = 8'h31;
    step();
    expect_val("R6 edge1", 4, 8'h00);
    step();
    expect_val("R6 edge2", 4, 8'h00);
    step();
    expect_val("R6 edge3", 4, 8'h01);
    expect_val("R9 wake", 5, 8'h01);

    // R7 clear loses to live mismatch
    flag_clr_i = 1'b1;
    step();
    flag_clr_i = 1'b0;
    expect_val("R7 set wins", 4, 8'h01);

    // R8 read then write in the same cycle
    rd_sel_i = 2'd0;
    wr_data_i = 1'b1; wdata_i = 8'h31;
    expect_val("R8 read before write", 0, 8'h31);
    step();
    wr_data_i = 1'b0;
    expect_val("R8 latch", 1, 8'h31);
    expect_val("R8 flag still set", 4, 8'h01);
    flag_clr_i = 1'b1;
    step();
    flag_clr_i = 1'b0;
    expect_val("R7 cleared", 4, 8'h00);
    expect_val("R9 wake low", 5, 8'h00);
    step();
    expect_val("R8 stays clear", 4, 8'h00);

    // R10 output pin changes ignored
    pin_in_i = 8'hB1;
    step(4);
    expect_val("R10 output pin change", 4, 8'h00);

    // R6 pin turned into an input while mismatching
    wr_dir_i = 1'b1; wdata_i = 8'hFF;
    step();
    wr_dir_i = 1'b0;
    expect_val("R6 dir edge1", 4, 8'h00);
    expect_val("R2 all inputs", 2, 8'h00);
    step();
    expect_val("R6 dir edge2", 4, 8'h01);
    expect_val("R9 wake dir", 5, 8'h01);
    step();

    done = 1;
    finish_test();
  end

endmodule